// File: doc/BRIEF.md
# Cascaded Second-Level Interrupt Aggregator

This block sits between a bank of up to 32 level-sensitive peripheral interrupt lines and a parent interrupt controller. It merges groups of lines onto a small number of grouped parent outputs. Each grouped output has its own membership mask, fixed at build time. A low-numbered subset of lines carries a mux gate. When a muxed line's forward bit is set, the line bypasses this stage and drives a dedicated parent output directly.

Software reaches the block through an 8-byte window of two 32-bit words. The word at byte offset 0x0 holds per-line enables. The word at byte offset 0x4 is read-only and shows the raw level of every line that belongs to a group. A build-time flag adds a combinational wake output, which asserts for any enabled, pending grouped line even while the register clock is stopped.

Top module: `irq_cascade_l2`

## Requirements
- R1: While `rst_n` is low at a rising edge, the enable word clears to zero and every `grp_irq` bit is low from the next edge onward.
- R2: A write (`reg_valid`=1, `reg_write`=1) to byte address 0x0 updates the enable word at the next edge. Only the bits of mapped lines are stored (0xFF8 in the default build). A read of address 0x0 returns the stored word.
- R3: A read of byte address 0x4 returns `irq_in` masked to the mapped lines. A write to 0x4 leaves the enable word unchanged.
- R4: `grp_irq[g]` is high one cycle after a cycle in which some line has its input high, its enable bit set, and its bit set in group g's mask. The default group 0 mask is 0xEB8 and the default group 1 mask is 0x140.
- R5: Clearing a line's enable bit keeps that line from raising any grouped output. A grouped output falls one cycle after its last enabled pending line drops.
- R6: Each forwarded line i (lines 0, 1, 2 with forward mask 0x7 in the default build) drives `fwd_irq[i]` combinationally from `irq_in[i]`. This holds whatever the enable word and reset are. Forwarded lines are removed from every group, from the status word and from the enable word.
- R7: Lines outside every group mask (12 to 31 by default) never affect `grp_irq` or `wake_irq`, and they read as zero in both words.
- R8: With the wake flag set, `wake_irq` is high in the same cycle in which any mapped line has its input high and its enable bit set. It is low otherwise.
- R9: `reg_rdata` is zero unless a read (`reg_valid`=1, `reg_write`=0) targets address 0x0 or 0x4. Any other address ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and output clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 32 | Level-sensitive peripheral interrupt lines |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 3 | Byte address within the 8-byte window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data |
| grp_irq | output | 2 | Registered grouped parent outputs |
| fwd_irq | output | 3 | Dedicated parent outputs of the muxed lines |
| wake_irq | output | 1 | Combinational wake request |

## Verification
The assertions check several relations on every cycle. A grouped output follows its pending-and-enabled condition one cycle later, in both directions. Forwarded outputs track their inputs. Unmapped bits never show in read data. An enable write lands while a status-word write leaves the enable word stable. Only the bench scenarios can show that a specific mask value routes a specific line to a specific group. The same holds for the readback values after masked writes, for lines 12 to 31 being inert under full enable, and for the wake output rising within the same cycle as its input.

// File: rtl/l2_cascade_pkg.sv
// Shared constants for the cascaded interrupt aggregator.
// Assumes a 32-bit register word and a byte-addressed two-word window.
package l2_cascade_pkg;
    localparam int WORD_W      = 32;
    localparam int WIN_ADDR_W  = 3;
    localparam logic [WIN_ADDR_W-1:0] OFS_ENABLE = 3'h0;
    localparam logic [WIN_ADDR_W-1:0] OFS_STATUS = 3'h4;
endpackage

// File: rtl/l2_enable_regs.sv
// Register window: enable word (read/write) and status word (read only).
// Assumes the status vector is already masked to mapped lines by the caller.
// Stores only the bits given by MAPPED; read data is combinational.
module l2_enable_regs
    import l2_cascade_pkg::*;
#(
    parameter int                 NUM_LINES = 32,
    parameter logic [NUM_LINES-1:0] MAPPED  = '0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  acc_valid,
    input  logic                  acc_write,
    input  logic [WIN_ADDR_W-1:0] acc_addr,
    input  logic [NUM_LINES-1:0]  acc_wdata,
    input  logic [NUM_LINES-1:0]  status_vec,
    output logic [NUM_LINES-1:0]  acc_rdata,
    output logic [NUM_LINES-1:0]  enable_vec
);
    logic [NUM_LINES-1:0] enable_q;
    logic                 wr_enable;
    logic                 rd_strobe;

    // Decode the write strobe that targets the enable word.
    always_comb begin
        wr_enable = acc_valid && acc_write && (acc_addr == OFS_ENABLE);
        rd_strobe = acc_valid && !acc_write;
    end

    // Hold the enable word, clearing it in reset and storing mapped bits only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_q <= '0;
        end else if (wr_enable) begin
            enable_q <= acc_wdata & MAPPED;
        end
    end

    // Select read data for the addressed word; zero on any other access.
    always_comb begin
        acc_rdata = '0;
        if (rd_strobe) begin
            if (acc_addr == OFS_ENABLE) begin
                acc_rdata = enable_q;
            end else if (acc_addr == OFS_STATUS) begin
                acc_rdata = status_vec;
            end
        end
    end

    assign enable_vec = enable_q;
endmodule

// File: rtl/l2_group_merge.sv
// Merges enabled, pending lines onto registered grouped outputs.
// Assumes GROUP_MASKS already excludes forwarded lines; one mask per group.
module l2_group_merge #(
    parameter int NUM_LINES  = 32,
    parameter int NUM_GROUPS = 2,
    parameter logic [NUM_GROUPS*NUM_LINES-1:0] GROUP_MASKS = '0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_LINES-1:0]  line_level,
    input  logic [NUM_LINES-1:0]  line_enable,
    output logic [NUM_GROUPS-1:0] group_out
);
    logic [NUM_LINES-1:0] active;

    // Lines that are both asserted and enabled.
    always_comb begin
        active = line_level & line_enable;
    end

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_group
        localparam logic [NUM_LINES-1:0] GMASK = GROUP_MASKS[g*NUM_LINES +: NUM_LINES];
        logic hit;
        logic out_q;

        // Reduce the active lines belonging to this group.
        always_comb begin
            hit = |(active & GMASK);
        end

        // Register the group output, low during reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                out_q <= 1'b0;
            end else begin
                out_q <= hit;
            end
        end

        assign group_out[g] = out_q;
    end
endmodule

// File: rtl/l2_fwd_route.sv
// Routes each muxed line to its dedicated parent output.
// A forwarded line passes straight through with no clock; a line that is not
// forwarded holds its dedicated output low and is served through the groups.
module l2_fwd_route #(
    parameter int                 NUM_FWD  = 3,
    parameter logic [NUM_FWD-1:0] FWD_BITS = '0
) (
    input  logic [NUM_FWD-1:0] mux_lines,
    output logic [NUM_FWD-1:0] direct_out
);
    for (genvar i = 0; i < NUM_FWD; i++) begin : g_mux
        if (FWD_BITS[i]) begin : g_pass
            assign direct_out[i] = mux_lines[i];
        end else begin : g_hold
            assign direct_out[i] = 1'b0;
        end
    end
endmodule

// File: rtl/irq_cascade_l2.sv
// Top of the cascaded second-level interrupt aggregator.
// Inputs are level-sensitive and assumed synchronous to clk where they feed
// the grouped outputs. Forwarded lines and the wake output are combinational.
// Group masks are packed with group 0 in the least significant word.
module irq_cascade_l2
    import l2_cascade_pkg::*;
#(
    parameter int NUM_LINES  = 32,
    parameter int NUM_GROUPS = 2,
    parameter int NUM_FWD    = 3,
    parameter logic [NUM_GROUPS*NUM_LINES-1:0] GROUP_MASKS = {32'h0000_0140, 32'h0000_0EB8},
    parameter logic [NUM_LINES-1:0] FWD_MASK = 32'h0000_0007,
    parameter bit WAKE_EN = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_LINES-1:0]  irq_in,
    input  logic                  reg_valid,
    input  logic                  reg_write,
    input  logic [WIN_ADDR_W-1:0] reg_addr,
    input  logic [NUM_LINES-1:0]  reg_wdata,
    output logic [NUM_LINES-1:0]  reg_rdata,
    output logic [NUM_GROUPS-1:0] grp_irq,
    output logic [NUM_FWD-1:0]    fwd_irq,
    output logic                  wake_irq
);
    // Forward bits only count on lines that carry a mux gate.
    localparam logic [NUM_LINES-1:0] MUX_LINES = NUM_LINES'((64'd1 << NUM_FWD) - 64'd1);
    localparam logic [NUM_LINES-1:0] FWD_EFF   = FWD_MASK & MUX_LINES;

    function automatic logic [NUM_GROUPS*NUM_LINES-1:0] strip_fwd(
        input logic [NUM_GROUPS*NUM_LINES-1:0] masks);
        logic [NUM_GROUPS*NUM_LINES-1:0] r;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            r[g*NUM_LINES +: NUM_LINES] = masks[g*NUM_LINES +: NUM_LINES] & ~FWD_EFF;
        end
        return r;
    endfunction

    function automatic logic [NUM_LINES-1:0] union_of(
        input logic [NUM_GROUPS*NUM_LINES-1:0] masks);
        logic [NUM_LINES-1:0] r;
        r = '0;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            r = r | masks[g*NUM_LINES +: NUM_LINES];
        end
        return r;
    endfunction

    localparam logic [NUM_GROUPS*NUM_LINES-1:0] GMASKS_EFF = strip_fwd(GROUP_MASKS);
    localparam logic [NUM_LINES-1:0]            MAPPED     = union_of(GMASKS_EFF);

    logic [NUM_LINES-1:0] status_vec;
    logic [NUM_LINES-1:0] en_vec;

    // Raw level of the lines that belong to some group.
    always_comb begin
        status_vec = irq_in & MAPPED;
    end

    l2_enable_regs #(
        .NUM_LINES (NUM_LINES),
        .MAPPED    (MAPPED)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_valid  (reg_valid),
        .acc_write  (reg_write),
        .acc_addr   (reg_addr),
        .acc_wdata  (reg_wdata),
        .status_vec (status_vec),
        .acc_rdata  (reg_rdata),
        .enable_vec (en_vec)
    );

    l2_group_merge #(
        .NUM_LINES   (NUM_LINES),
        .NUM_GROUPS  (NUM_GROUPS),
        .GROUP_MASKS (GMASKS_EFF)
    ) u_merge (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_level  (status_vec),
        .line_enable (en_vec),
        .group_out   (grp_irq)
    );

    l2_fwd_route #(
        .NUM_FWD  (NUM_FWD),
        .FWD_BITS (FWD_EFF[NUM_FWD-1:0])
    ) u_fwd (
        .mux_lines  (irq_in[NUM_FWD-1:0]),
        .direct_out (fwd_irq)
    );

    // Wake request: combinational so it works with the clock stopped.
    if (WAKE_EN) begin : g_wake
        assign wake_irq = |(status_vec & en_vec);
    end else begin : g_nowake
        assign wake_irq = 1'b0;
    end
endmodule

// File: rtl/l2_cascade_chk.sv
// Property checker for irq_cascade_l2, attached with the bind below.
// Assumes the same parameter values as the bound instance.
module l2_cascade_chk
    import l2_cascade_pkg::*;
#(
    parameter int NUM_LINES  = 32,
    parameter int NUM_GROUPS = 2,
    parameter int NUM_FWD    = 3,
    parameter logic [NUM_GROUPS*NUM_LINES-1:0] GROUP_MASKS = '0,
    parameter logic [NUM_LINES-1:0] FWD_MASK = '0
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NUM_LINES-1:0]  irq_in,
    input logic                  reg_valid,
    input logic                  reg_write,
    input logic [WIN_ADDR_W-1:0] reg_addr,
    input logic [NUM_LINES-1:0]  reg_wdata,
    input logic [NUM_LINES-1:0]  reg_rdata,
    input logic [NUM_GROUPS-1:0] grp_irq,
    input logic [NUM_FWD-1:0]    fwd_irq,
    input logic                  wake_irq,
    input logic [NUM_LINES-1:0]  en_vec
);
    localparam logic [NUM_LINES-1:0] FWD_LOW = FWD_MASK & NUM_LINES'((64'd1 << NUM_FWD) - 64'd1);

    function automatic logic [NUM_LINES-1:0] all_groups();
        logic [NUM_LINES-1:0] r;
        r = '0;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            r = r | GROUP_MASKS[g*NUM_LINES +: NUM_LINES];
        end
        return r & ~FWD_LOW;
    endfunction

    localparam logic [NUM_LINES-1:0] MAPPED = all_groups();

    assert_grp_reset_R1: assert property (@(posedge clk)
        !rst_n |=> grp_irq == '0);

    assert_en_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_valid && reg_write && reg_addr == OFS_ENABLE)
        |=> en_vec == ($past(reg_wdata) & MAPPED));

    assert_status_ro_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_valid && reg_write && reg_addr == OFS_STATUS) |=> $stable(en_vec));

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        localparam logic [NUM_LINES-1:0] GM = GROUP_MASKS[g*NUM_LINES +: NUM_LINES] & ~FWD_LOW;

        assert_grp_fire_R4: assert property (@(posedge clk) disable iff (!rst_n)
            ((irq_in & en_vec & GM) != '0) |=> grp_irq[g]);

        assert_grp_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
            ((irq_in & en_vec & GM) == '0) |=> !grp_irq[g]);
    end

    for (genvar i = 0; i < NUM_FWD; i++) begin : g_fwd
        if (FWD_LOW[i]) begin : g_on
            assert_fwd_follow_R6: assert property (@(posedge clk)
                fwd_irq[i] == irq_in[i]);
        end
    end

    assert_unmapped_zero_R7: assert property (@(posedge clk)
        (reg_rdata & ~MAPPED) == '0);

    assert_wake_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wake_irq |-> (irq_in & MAPPED) != '0);

    assert_rdata_idle_R9: assert property (@(posedge clk)
        !(reg_valid && !reg_write) |-> reg_rdata == '0);
endmodule

bind irq_cascade_l2 l2_cascade_chk #(
    .NUM_LINES   (NUM_LINES),
    .NUM_GROUPS  (NUM_GROUPS),
    .NUM_FWD     (NUM_FWD),
    .GROUP_MASKS (GROUP_MASKS),
    .FWD_MASK    (FWD_MASK)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_in    (irq_in),
    .reg_valid (reg_valid),
    .reg_write (reg_write),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .grp_irq   (grp_irq),
    .fwd_irq   (fwd_irq),
    .wake_irq  (wake_irq),
    .en_vec    (en_vec)
);

// File: tb/irq_cascade_l2_test.sv
`timescale 1ns/1ps
// Bench for irq_cascade_l2: a behavioural per-line model is stepped on every
// rising edge and compared with the outputs 1 ns later; directed register
// checks cover readback, masking and ignored accesses.
module irq_cascade_l2_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_in = '0;
    logic        reg_valid = 1'b0;
    logic        reg_write = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [1:0]  grp_irq;
    logic [2:0]  fwd_irq;
    logic        wake_irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // Model state.
    bit [31:0] m_en = '0;
    bit [1:0]  m_grp = '0;
    int        g_of[32];

    always #2 clk = ~clk;

    irq_cascade_l2 uut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .reg_valid(reg_valid), .reg_write(reg_write), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .grp_irq(grp_irq), .fwd_irq(fwd_irq), .wake_irq(wake_irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Group of each line per the requirements: -1 means not in any group.
    initial begin
        for (int i = 0; i < 32; i++) g_of[i] = -1;
        g_of[3] = 0; g_of[4] = 0; g_of[5] = 0; g_of[7] = 0;
        g_of[9] = 0; g_of[10] = 0; g_of[11] = 0;
        g_of[6] = 1; g_of[8] = 1;
    end

    // Step the model at each edge, then compare every output 1 ns later.
    always @(posedge clk) begin
        bit [1:0] nxt;
        bit       wk;
        nxt = '0;
        if (!rst_n) begin
            m_en  = '0;
            m_grp = '0;
        end else begin
            for (int i = 0; i < 32; i++)
                if (g_of[i] >= 0 && irq_in[i] && m_en[i]) nxt[g_of[i]] = 1'b1;
            m_grp = nxt;
            if (reg_valid && reg_write && reg_addr == 3'h0) begin
                m_en = '0;
                for (int i = 0; i < 32; i++)
                    if (g_of[i] >= 0) m_en[i] = reg_wdata[i];
            end
        end
        #1;
        wk = 1'b0;
        for (int i = 0; i < 32; i++)
            if (g_of[i] >= 0 && irq_in[i] && m_en[i]) wk = 1'b1;
        check("R4/R5 grp_irq", {30'd0, grp_irq}, {30'd0, m_grp});
        check("R6 fwd_irq", {29'd0, fwd_irq}, {29'd0, irq_in[2:0]});
        check("R8 wake_irq", {31'd0, wake_irq}, {31'd0, wk});
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_valid = 1'b0; reg_write = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [2:0] a, input logic [31:0] exp);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
        #1 check(tag, reg_rdata, exp);
        @(negedge clk);
        reg_valid = 1'b0;
    endtask

    task automatic drive(input logic [31:0] v, input int cycles);
        @(negedge clk);
        irq_in = v;
        repeat (cycles) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state seen while reset is held.
        check("R1 grp in reset", {30'd0, grp_irq}, 32'd0);
        rst_n = 1'b1;
        rd("R1 enable after reset", 3'h0, 32'h0);
        // R2/R7: only mapped enables stick.
        wr(3'h0, 32'hFFFF_FFFF);
        rd("R2 enable readback", 3'h0, 32'h0000_0FF8);
        // R4: line 4 to group 0, line 6 to group 1, both, then none.
        drive(32'h0000_0010, 2);
        check("R4 group0 line4", {30'd0, grp_irq}, 32'd1);
        drive(32'h0000_0040, 2);
        check("R4 group1 line6", {30'd0, grp_irq}, 32'd2);
        drive(32'h0000_0900, 2);
        check("R4 both groups", {30'd0, grp_irq}, 32'd3);
        drive(32'h0, 2);
        check("R5 drop after release", {30'd0, grp_irq}, 32'd0);
        // R5: disabled line is masked.
        wr(3'h0, 32'hFFFF_FFEF);
        drive(32'h0000_0010, 3);
        check("R5 disabled line4", {30'd0, grp_irq}, 32'd0);
        check("R5 wake disabled", {31'd0, wake_irq}, 32'd0);
        // R6: forwarded lines ignore enables and stay out of groups.
        wr(3'h0, 32'h0);
        drive(32'h0000_0005, 2);
        check("R6 forward pass", {29'd0, fwd_irq}, 32'd5);
        check("R6 no group", {30'd0, grp_irq}, 32'd0);
        // R7: unmapped lines are inert.
        wr(3'h0, 32'hFFFF_FFFF);
        drive(32'hFFFF_F000, 3);
        check("R7 unmapped grp", {30'd0, grp_irq}, 32'd0);
        check("R7 unmapped wake", {31'd0, wake_irq}, 32'd0);
        // R3: status shows mapped raw levels only; writes ignored.
        drive(32'h0000_F147, 1);
        rd("R3 status", 3'h4, 32'h0000_0140);
        wr(3'h4, 32'h0);
        rd("R3 status write ignored", 3'h0, 32'h0000_0FF8);
        // R9: other addresses and idle bus.
        wr(3'h1, 32'h0);
        rd("R9 odd address write ignored", 3'h0, 32'h0000_0FF8);
        rd("R9 odd address read", 3'h2, 32'h0);
        #1 check("R9 idle rdata", reg_rdata, 32'h0);
        // R8: wake rises in the same cycle as the input.
        drive(32'h0, 1);
        @(negedge clk);
        irq_in = 32'h0000_0200;
        #1 check("R8 wake same cycle", {31'd0, wake_irq}, 32'd1);
        // R1: reset clears enables and groups.
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 grp after reset", {30'd0, grp_irq}, 32'd0);
        rst_n = 1'b1;
        rd("R1 enable cleared", 3'h0, 32'h0);
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #20000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule